// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

This is a purely combinational 64-bit integer execution slice. Each evaluation takes operand A and a second operand, plus a 7-bit function code. The second operand comes either from a 64-bit register input or from an 8-bit literal. The unit returns a 64-bit result, an overflow-trap flag and an illegal-function flag.

The supported work covers four groups:
- 32-bit ("long") and 64-bit ("quad") add and subtract.
- Scaled add and subtract, where A is first shifted left by 2 or by 3.
- Trapping add and subtract, which report signed overflow.
- Equality, signed and unsigned ordering compares, and a byte-lane compare that returns one mask bit per byte.

Long results are always sign-extended from bit 31. A surrounding pipeline stage places the unit between its operand latches and its writeback latch, and uses the overflow flag to raise an arithmetic trap.

Top module: `int_arith_unit`

## Requirements
- R1: Function 0x00 gives A[31:0]+B[31:0] and function 0x09 gives A[31:0]-B[31:0]; each 32-bit value is sign-extended from bit 31 into bits 63:32.
- R2: Function 0x20 gives the 64-bit sum A+B and function 0x29 gives the 64-bit difference A-B, both modulo 2^64.
- R3: Scaled adds give (A<<2)+B for 0x02 (long) and 0x22 (quad), and (A<<3)+B for 0x12 (long) and 0x32 (quad). Long forms keep the low 32 bits and sign-extend them.
- R4: Scaled subtracts give (A<<2)-B for 0x0b (long) and 0x2b (quad), and (A<<3)-B for 0x1b (long) and 0x3b (quad). Long forms keep the low 32 bits and sign-extend them.
- R5: Trapping adds 0x40 (long, sign bit 31) and 0x60 (quad, sign bit 63) return the plain sum. They raise the overflow flag exactly when A and B share a sign bit and the result's sign bit differs from A's.
- R6: Trapping subtracts 0x49 (long) and 0x69 (quad) return the plain difference. They raise the overflow flag exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R7: The overflow flag stays low for every function code other than 0x40, 0x60, 0x49 and 0x69.
- R8: Compares return 1 or 0 in bit 0, with bits 63:1 zero. The codes are 0x2d for A==B, 0x6d for signed A<=B, 0x4d for signed A<B, 0x3d for unsigned A<=B and 0x1d for unsigned A<B.
- R9: Function 0x0f sets result bit i (i=0..7) when unsigned byte i of A (bits 8i+7:8i) is greater than or equal to byte i of B; bits 63:8 are zero.
- R10: When the immediate select is high, B is the 8-bit literal zero-extended to 64 bits, and the register B input has no effect on the outputs.
- R11: Any function code other than the 22 listed in R1 to R9 gives a zero result, a high illegal-function flag and a low overflow flag. The illegal-function flag is low for the 22 listed codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Register form of operand B |
| imm_lit | input | 8 | Literal form of operand B |
| use_imm | input | 1 | 1 selects the zero-extended literal as B |
| func | input | 7 | Function code |
| result | output | 64 | Computed result |
| ovf_trap | output | 1 | Signed overflow on a trapping function |
| bad_func | output | 1 | Function code not implemented |

## Verification
Because the unit holds no state, every fault in it shows at the ports in the same evaluation that triggers it; nothing can lie hidden for later cycles. A wrong decode shows up in two ways: a wrong scale or width on some code, or a legal code flagged illegal. A broken sign-extension shows as a wrong upper word on long results whose bit 31 is set. Errors in the overflow rule or the byte lanes appear only for particular sign and byte patterns, so the bench drives the boundary values at bit 31, bit 63 and each byte lane, as well as random sweeps over all 128 codes.

// File: rtl/iau_pkg.sv
package iau_pkg;

    localparam int DATA_W = 64;
    localparam int LONG_W = 32;
    localparam int LANE_W = 8;
    localparam int IMM_W  = 8;
    localparam int FUNC_W = 7;
    localparam int SCL_W  = 2;

    typedef enum logic [1:0] {
        K_NONE,
        K_ARITH,
        K_CMP,
        K_BYTE
    } kind_e;

    typedef enum logic [2:0] {
        C_EQ,
        C_SLE,
        C_SLT,
        C_ULE,
        C_ULT
    } cmp_e;

    typedef struct packed {
        logic              legal;
        kind_e             kind;
        logic              is_long;
        logic              sub;
        logic              trap;
        logic [SCL_W-1:0]  scale;
        cmp_e              cmp;
    } op_ctl_t;

    function automatic op_ctl_t arith_op(input logic lng, input logic sb,
                                         input logic tr, input logic [SCL_W-1:0] sc);
        op_ctl_t o;
        o.legal   = 1'b1;
        o.kind    = K_ARITH;
        o.is_long = lng;
        o.sub     = sb;
        o.trap    = tr;
        o.scale   = sc;
        o.cmp     = C_EQ;
        return o;
    endfunction

    function automatic op_ctl_t cmp_op(input cmp_e c);
        op_ctl_t o;
        o.legal   = 1'b1;
        o.kind    = K_CMP;
        o.is_long = 1'b0;
        o.sub     = 1'b0;
        o.trap    = 1'b0;
        o.scale   = '0;
        o.cmp     = c;
        return o;
    endfunction

endpackage

// File: rtl/iau_decode.sv
module iau_decode
    import iau_pkg::*;
#(
    parameter int FW = FUNC_W
) (
    input  logic [FW-1:0] func,
    output op_ctl_t       ctl
);
    always_comb begin
        ctl = '0;
        ctl.kind = K_NONE;
        ctl.cmp  = C_EQ;
        case (func)
            7'h00: ctl = arith_op(1'b1, 1'b0, 1'b0, 2'd0);
            7'h09: ctl = arith_op(1'b1, 1'b1, 1'b0, 2'd0);
            7'h20: ctl = arith_op(1'b0, 1'b0, 1'b0, 2'd0);
            7'h29: ctl = arith_op(1'b0, 1'b1, 1'b0, 2'd0);
            7'h02: ctl = arith_op(1'b1, 1'b0, 1'b0, 2'd2);
            7'h12: ctl = arith_op(1'b1, 1'b0, 1'b0, 2'd3);
            7'h22: ctl = arith_op(1'b0, 1'b0, 1'b0, 2'd2);
            7'h32: ctl = arith_op(1'b0, 1'b0, 1'b0, 2'd3);
            7'h0b: ctl = arith_op(1'b1, 1'b1, 1'b0, 2'd2);
            7'h1b: ctl = arith_op(1'b1, 1'b1, 1'b0, 2'd3);
            7'h2b: ctl = arith_op(1'b0, 1'b1, 1'b0, 2'd2);
            7'h3b: ctl = arith_op(1'b0, 1'b1, 1'b0, 2'd3);
            7'h40: ctl = arith_op(1'b1, 1'b0, 1'b1, 2'd0);
            7'h60: ctl = arith_op(1'b0, 1'b0, 1'b1, 2'd0);
            7'h49: ctl = arith_op(1'b1, 1'b1, 1'b1, 2'd0);
            7'h69: ctl = arith_op(1'b0, 1'b1, 1'b1, 2'd0);
            7'h2d: ctl = cmp_op(C_EQ);
            7'h6d: ctl = cmp_op(C_SLE);
            7'h4d: ctl = cmp_op(C_SLT);
            7'h3d: ctl = cmp_op(C_ULE);
            7'h1d: ctl = cmp_op(C_ULT);
            7'h0f: begin
                ctl.legal = 1'b1;
                ctl.kind  = K_BYTE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/iau_addsub.sv
module iau_addsub
    import iau_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int HW = LONG_W
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [SCL_W-1:0] scale,
    input  logic             sub,
    input  logic             is_long,
    output logic [W-1:0]     sum_o,
    output logic             ovf_o
);
    localparam int EXT_W = W - HW;

    logic [W-1:0] a_sh;
    logic [W-1:0] raw;
    logic         sa, sb, sr;

    always_comb begin
        a_sh = a << scale;
        raw  = sub ? (a_sh - b) : (a_sh + b);
        if (is_long) begin
            sum_o = {{EXT_W{raw[HW-1]}}, raw[HW-1:0]};
            sa    = a[HW-1];
            sb    = b[HW-1];
            sr    = raw[HW-1];
        end else begin
            sum_o = raw;
            sa    = a[W-1];
            sb    = b[W-1];
            sr    = raw[W-1];
        end
        ovf_o = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    end
endmodule

// File: rtl/iau_compare.sv
module iau_compare
    import iau_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  cmp_e         sel,
    output logic         hit
);
    logic eq, slt, ult;

    always_comb begin
        eq  = (a == b);
        slt = ($signed(a) < $signed(b));
        ult = (a < b);
        case (sel)
            C_EQ:    hit = eq;
            C_SLE:   hit = slt | eq;
            C_SLT:   hit = slt;
            C_ULE:   hit = ult | eq;
            C_ULT:   hit = ult;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/iau_bytecmp.sv
module iau_bytecmp
    import iau_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int LANE = LANE_W
) (
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    output logic [W/LANE-1:0]    ge_mask
);
    localparam int NLANE = W / LANE;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign ge_mask[g] = (a[g*LANE +: LANE] >= b[g*LANE +: LANE]);
    end
endmodule

// File: rtl/int_arith_unit.sv
module int_arith_unit
    import iau_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int HW   = LONG_W,
    parameter int IW   = IMM_W,
    parameter int FW   = FUNC_W,
    parameter int LANE = LANE_W
) (
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [IW-1:0] imm_lit,
    input  logic          use_imm,
    input  logic [FW-1:0] func,
    output logic [W-1:0]  result,
    output logic          ovf_trap,
    output logic          bad_func
);
    localparam int NLANE = W / LANE;

    op_ctl_t           ctl;
    logic [W-1:0]      b_eff;
    logic [W-1:0]      as_sum;
    logic              as_ovf;
    logic              cmp_hit;
    logic [NLANE-1:0]  lane_ge;

    assign b_eff = use_imm ? {{(W-IW){1'b0}}, imm_lit} : opnd_b;

    iau_decode #(.FW(FW)) u_dec (
        .func (func),
        .ctl  (ctl)
    );

    iau_addsub #(.W(W), .HW(HW)) u_add (
        .a       (opnd_a),
        .b       (b_eff),
        .scale   (ctl.scale),
        .sub     (ctl.sub),
        .is_long (ctl.is_long),
        .sum_o   (as_sum),
        .ovf_o   (as_ovf)
    );

    iau_compare #(.W(W)) u_cmp (
        .a   (opnd_a),
        .b   (b_eff),
        .sel (ctl.cmp),
        .hit (cmp_hit)
    );

    iau_bytecmp #(.W(W), .LANE(LANE)) u_byte (
        .a       (opnd_a),
        .b       (b_eff),
        .ge_mask (lane_ge)
    );

    always_comb begin
        case (ctl.kind)
            K_ARITH: result = as_sum;
            K_CMP:   result = {{(W-1){1'b0}}, cmp_hit};
            K_BYTE:  result = {{(W-NLANE){1'b0}}, lane_ge};
            default: result = '0;
        endcase
        ovf_trap = ctl.legal & ctl.trap & as_ovf;
        bad_func = ~ctl.legal;
    end
endmodule

// File: rtl/iau_chk.sv
module iau_chk #(
    parameter int W  = 64,
    parameter int HW = 32,
    parameter int FW = 7
) (
    input logic [W-1:0]  opnd_a,
    input logic [W-1:0]  opnd_b,
    input logic [FW-1:0] func,
    input logic [W-1:0]  result,
    input logic          ovf_trap,
    input logic          bad_func
);
    logic is_trap_code, is_cmp_code, is_long_code;

    always_comb begin
        is_trap_code = (func == 7'h40) || (func == 7'h60) ||
                       (func == 7'h49) || (func == 7'h69);
        is_cmp_code  = (func == 7'h2d) || (func == 7'h6d) || (func == 7'h4d) ||
                       (func == 7'h3d) || (func == 7'h1d);
        is_long_code = (func == 7'h00) || (func == 7'h09) || (func == 7'h02) ||
                       (func == 7'h12) || (func == 7'h0b) || (func == 7'h1b) ||
                       (func == 7'h40) || (func == 7'h49);

        // R11
        illegal_quiet_chk: assert (!bad_func || (result == '0 && !ovf_trap))
            else $error("illegal code produced output");
        // R7
        no_overflow_chk: assert (is_trap_code || !ovf_trap)
            else $error("overflow on non-trapping code");
        // R8
        cmp_bool_chk: assert (!is_cmp_code || result[W-1:1] == '0)
            else $error("compare result not boolean");
        // R9
        lane_mask_chk: assert (func != 7'h0f || result[W-1:8] == '0)
            else $error("byte compare upper bits set");
        // R1
        long_sext_chk: assert (!is_long_code ||
                               result[W-1:HW] == {(W-HW){result[HW-1]}})
            else $error("long result not sign-extended");
    end
endmodule

bind int_arith_unit iau_chk #(.W(W), .HW(HW), .FW(FW)) u_iau_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .func     (func),
    .result   (result),
    .ovf_trap (ovf_trap),
    .bad_func (bad_func)
);

// File: tb/test_int_arith_unit.sv
module test_int_arith_unit;

    logic        clk = 1'b0;
    logic [63:0] opnd_a;
    logic [63:0] opnd_b;
    logic [7:0]  imm_lit;
    logic        use_imm;
    logic [6:0]  func;
    logic [63:0] result;
    logic        ovf_trap;
    logic        bad_func;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    int_arith_unit i_int_arith_unit (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .imm_lit  (imm_lit),
        .use_imm  (use_imm),
        .func     (func),
        .result   (result),
        .ovf_trap (ovf_trap),
        .bad_func (bad_func)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s func=%02h actual=%016h expected=%016h", tag, func, act, exp);
        end
    endtask

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // Independent model derived from R1..R11
    task automatic model(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic o, output logic il);
        logic [31:0] l;
        logic [63:0] q;
        r = 64'd0; o = 1'b0; il = 1'b0;
        case (f)
            7'h00, 7'h40: begin l = a[31:0] + b[31:0]; r = sx32(l);
                if (f == 7'h40) o = (a[31] == b[31]) && (l[31] != a[31]); end
            7'h09, 7'h49: begin l = a[31:0] - b[31:0]; r = sx32(l);
                if (f == 7'h49) o = (a[31] != b[31]) && (l[31] != a[31]); end
            7'h20, 7'h60: begin q = a + b; r = q;
                if (f == 7'h60) o = (a[63] == b[63]) && (q[63] != a[63]); end
            7'h29, 7'h69: begin q = a - b; r = q;
                if (f == 7'h69) o = (a[63] != b[63]) && (q[63] != a[63]); end
            7'h02: r = sx32(a[31:0] * 4 + b[31:0]);
            7'h12: r = sx32(a[31:0] * 8 + b[31:0]);
            7'h22: r = a * 4 + b;
            7'h32: r = a * 8 + b;
            7'h0b: r = sx32(a[31:0] * 4 - b[31:0]);
            7'h1b: r = sx32(a[31:0] * 8 - b[31:0]);
            7'h2b: r = a * 4 - b;
            7'h3b: r = a * 8 - b;
            7'h2d: r = {63'd0, a == b};
            7'h6d: r = {63'd0, $signed(a) <= $signed(b)};
            7'h4d: r = {63'd0, $signed(a) < $signed(b)};
            7'h3d: r = {63'd0, a <= b};
            7'h1d: r = {63'd0, a < b};
            7'h0f: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
            default: il = 1'b1;
        endcase
    endtask

    task automatic drive(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
        @(posedge clk);
        func = f; opnd_a = a; opnd_b = b; use_imm = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk("R1 idle result", result, 64'd0);
        chk("R7 idle ovf", {63'd0, ovf_trap}, 64'd0);
        chk("R11 idle bad_func", {63'd0, bad_func}, 64'd0);
    endtask

    task automatic t_long_addsub;
        drive(7'h00, 64'hAAAA_0000_7FFF_FFFF, 64'h5555_0000_0000_0001);
        chk("R1 long add sext", result, 64'hFFFF_FFFF_8000_0000);
        drive(7'h09, 64'h0, 64'h1);
        chk("R1 long sub", result, 64'hFFFF_FFFF_FFFF_FFFF);
        drive(7'h00, 64'hFFFF_FFFF_0000_0003, 64'h0000_0001_0000_0004);
        chk("R1 long add positive", result, 64'h7);
    endtask

    task automatic t_quad_addsub;
        drive(7'h20, 64'h0000_0000_FFFF_FFFF, 64'h1);
        chk("R2 quad add carry", result, 64'h1_0000_0000);
        drive(7'h29, 64'h0, 64'h1);
        chk("R2 quad sub wrap", result, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_scaled;
        drive(7'h12, 64'h2000_0000, 64'h5);
        chk("R3 long s8 add trunc", result, 64'h5);
        drive(7'h32, 64'h2000_0000, 64'h5);
        chk("R3 quad s8 add", result, 64'h1_0000_0005);
        drive(7'h02, 64'h3, 64'h1);
        chk("R3 long s4 add", result, 64'hD);
        drive(7'h0b, 64'h1, 64'h5);
        chk("R4 long s4 sub", result, 64'hFFFF_FFFF_FFFF_FFFF);
        drive(7'h3b, 64'h10, 64'h8);
        chk("R4 quad s8 sub", result, 64'h78);
    endtask

    task automatic t_trap_add;
        drive(7'h40, 64'h7FFF_FFFF, 64'h1);
        chk("R5 long trap add res", result, 64'hFFFF_FFFF_8000_0000);
        chk("R5 long trap add ovf", {63'd0, ovf_trap}, 64'd1);
        drive(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
        chk("R5 quad trap add res", result, 64'h8000_0000_0000_0000);
        chk("R5 quad trap add ovf", {63'd0, ovf_trap}, 64'd1);
        drive(7'h60, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        chk("R5 quad mixed sign no ovf", {63'd0, ovf_trap}, 64'd0);
        drive(7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
        chk("R7 plain add no ovf", {63'd0, ovf_trap}, 64'd0);
    endtask

    task automatic t_trap_sub;
        drive(7'h49, 64'h8000_0000, 64'h1);
        chk("R6 long trap sub res", result, 64'h7FFF_FFFF);
        chk("R6 long trap sub ovf", {63'd0, ovf_trap}, 64'd1);
        drive(7'h69, 64'h8000_0000_0000_0000, 64'h1);
        chk("R6 quad trap sub ovf", {63'd0, ovf_trap}, 64'd1);
        drive(7'h69, 64'h5, 64'h7);
        chk("R6 quad same sign no ovf", {63'd0, ovf_trap}, 64'd0);
    endtask

    task automatic t_compares;
        drive(7'h4d, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        chk("R8 signed lt", result, 64'd1);
        drive(7'h1d, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        chk("R8 unsigned lt", result, 64'd0);
        drive(7'h6d, 64'h5, 64'h5);
        chk("R8 signed le eq", result, 64'd1);
        drive(7'h3d, 64'h6, 64'h5);
        chk("R8 unsigned le gt", result, 64'd0);
        drive(7'h2d, 64'h1234, 64'h1234);
        chk("R8 equal", result, 64'd1);
    endtask

    task automatic t_bytecmp;
        drive(7'h0f, 64'h00FF_1080_0000_0001, 64'h0100_1080_7F00_0000);
        chk("R9 byte mask", result, 64'h77);
        drive(7'h0f, 64'h0, 64'h0);
        chk("R9 all equal", result, 64'hFF);
    endtask

    task automatic t_immediate;
        @(posedge clk);
        func = 7'h20; opnd_a = 64'h10; opnd_b = 64'hDEAD_BEEF_0000_1111;
        imm_lit = 8'h85; use_imm = 1'b1;
        @(negedge clk);
        chk("R10 imm add", result, 64'h95);
        @(posedge clk);
        func = 7'h1d; opnd_a = 64'h84; opnd_b = 64'h0;
        @(negedge clk);
        chk("R10 imm zero-ext compare", result, 64'd1);
        @(posedge clk);
        opnd_b = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        chk("R10 reg B ignored", result, 64'd1);
        @(posedge clk);
        use_imm = 1'b0;
    endtask

    task automatic t_all_codes;
        logic [63:0] er;
        logic eo, ei;
        for (int f = 0; f < 128; f++) begin
            for (int k = 0; k < 6; k++) begin
                logic [63:0] a, b;
                a = {$urandom, $urandom};
                b = {$urandom, $urandom};
                if (k == 0) b = a;
                if (k == 1) begin a = 64'h8000_0000_8000_0000; b = 64'h8000_0000_8000_0000; end
                drive(f[6:0], a, b);
                model(f[6:0], a, b, er, eo, ei);
                chk("R11 sweep result", result, er);
                chk("R7 sweep ovf", {63'd0, ovf_trap}, {63'd0, eo});
                chk("R11 sweep bad_func", {63'd0, bad_func}, {63'd0, ei});
            end
        end
    endtask

    initial begin
        func = 7'h00; opnd_a = '0; opnd_b = '0; imm_lit = '0; use_imm = 1'b0;
        t_reset_state();
        t_long_addsub();
        t_quad_addsub();
        t_scaled();
        t_trap_add();
        t_trap_sub();
        t_compares();
        t_bytecmp();
        t_immediate();
        t_all_codes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule